// File: doc/BRIEF.md
# Carry-Tap Periodic Interrupt Timer

This block is an 8-bit timer that advances by one on each 256 Hz tick. The tick is a one-cycle strobe made by a prescaler outside the block. Software runs the timer through a small register port with four addresses: a control register, a read-only count, a pending-interrupt register and an acknowledge register.

Four periodic interrupt requests are taken straight from the counter's carry chain; no compare registers are used. A request fires when a carry enters bit 3, bit 5 or bit 7 of the count, or when the whole count wraps. At the default tick rate these give 32 Hz, 8 Hz, 2 Hz and 1 Hz. Each request has a fixed vector number and stays latched as a pending flag until software acknowledges it. Priority arbitration between the requests is left to the interrupt controller downstream.

Top module: `rate_tap_timer`

## Requirements
- R1: Writing address 0 (control) sets the enable flag from data bit 0. A read of address 0 returns the enable flag in bit 0, and all other bits read as 0.
- R2: Writing 1 to control data bit 1 clears the count to 0 at that clock edge, even when a tick arrives in the same cycle. This clear bit is a one-cycle strobe and is not stored.
- R3: While enabled, each tick adds one to the count, and the count wraps from 255 to 0. A read of address 1 returns the count.
- R4: While disabled, ticks are ignored and the count holds its value.
- R5: At an enabled tick, pending bit 0 (vector 0x0B) sets when count bits 2..0 are all ones. Pending bit 1 (0x0C) sets when bits 4..0 are all ones, and pending bit 2 (0x0D) sets when bits 6..0 are all ones. Pending bit 3 (0x0E) sets when all 8 bits are ones. Address 2 reads the pending flags in bits 3..0.
- R6: Pending flags are sticky. Writing 1 to a bit position at address 3 clears that flag, and writing 0 to a position leaves that flag unchanged.
- R7: If a flag is set and acknowledged in the same cycle, the set takes effect and the flag stays set.
- R8: The tick that wraps the count from 255 to 0 sets all four pending flags together.
- R9: Clearing the count through the control register never sets a pending flag.
- R10: `rd_data` shows the register chosen by `rd_addr` one clock later. Address 3 reads as 0.
- R11: `irq_vectors` carries the vector of pending bit i in byte i: 0x0B, 0x0C, 0x0D and 0x0E.
- R12: After synchronous reset the count is 0, the timer is disabled and no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 256 Hz count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| irq_pending | output | 4 | Pending interrupt flags, one per rate |
| irq_vectors | output | 32 | Fixed vector number for each pending bit |

## Verification
The bench builds the block with its default parameters: an 8-bit count, four taps and vector base 0x0B. It drives the tick input directly, one strobe per cycle, so a full 256-tick wrap fits in a few hundred cycles. That makes every carry tap reachable, including the cycle where all four taps fire together. The short run also reaches the same-cycle collisions: a clear against a tick, and an acknowledge against a set.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_ACK   = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_CLEAR_BIT = 1;

  // Carry tap i watches the low tap_pos bits; the last tap saturates at the
  // full counter width and so marks a complete wrap.
  function automatic int tap_pos(input int idx, input int cnt_w);
    int p;
    p = 3 + 2 * idx;
    return (p > cnt_w) ? cnt_w : p;
  endfunction

endpackage

// File: rtl/rtt_ctrl_regs.sv
module rtt_ctrl_regs
  import rtt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                enable,
  output logic                clear_pulse,
  output logic [NUM_TAPS-1:0] ack_mask
);

  logic ctrl_wr;
  logic ack_wr;

  assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
  assign ack_wr  = wr_en && (wr_addr == SEL_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
    end else if (ctrl_wr) begin
      enable <= wr_data[CTRL_EN_BIT];
    end
  end

  assign clear_pulse = ctrl_wr && wr_data[CTRL_CLEAR_BIT];
  assign ack_mask    = ack_wr ? wr_data[NUM_TAPS-1:0] : '0;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  // R1: enable changes only through a control write
  a_r1_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(enable));

  a_r1_enable_load: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (enable == $past(wr_data[CTRL_EN_BIT])));

endmodule

// File: rtl/rtt_counter.sv
module rtt_counter
  import rtt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                enable,
  input  logic                clear,
  output logic [CNT_W-1:0]    count,
  output logic [NUM_TAPS-1:0] tap_fire
);

  logic advance;
  assign advance = tick && enable && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (advance) begin
      count <= count + 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    localparam int         POS  = tap_pos(gi, CNT_W);
    localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << POS) - 64'd1);
    assign tap_fire[gi] = advance && ((count & MASK) == MASK);
  end

  // R2: a clear wins over a tick
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));

  // R3: one step per enabled tick, wrapping at the top
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (tick && enable && !clear) |=> (count == $past(count) + 1'b1));

  // R4: disabled means frozen
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clear) |=> $stable(count));

endmodule

// File: rtl/rtt_pending.sv
module rtt_pending #(
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] fire,
  input  logic [NUM_TAPS-1:0] ack,
  output logic [NUM_TAPS-1:0] pending
);

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[gi] <= 1'b0;
      end else if (fire[gi]) begin
        pending[gi] <= 1'b1;
      end else if (ack[gi]) begin
        pending[gi] <= 1'b0;
      end
    end

    // R6: a flag only drops on its own acknowledge
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
      (pending[gi] && !ack[gi]) |=> pending[gi]);

    // R7: a set in the acknowledge cycle survives
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
      fire[gi] |=> pending[gi]);
  end

endmodule

// File: rtl/rate_tap_timer.sv
module rate_tap_timer
  import rtt_pkg::*;
#(
  parameter int          CNT_W    = 8,
  parameter int          DATA_W   = 8,
  parameter int          NUM_TAPS = 4,
  parameter logic [7:0]  VEC_BASE = 8'h0B
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_TAPS-1:0]   irq_pending,
  output logic [NUM_TAPS*8-1:0] irq_vectors
);

  logic                enable;
  logic                clear_pulse;
  logic [NUM_TAPS-1:0] ack_mask;
  logic [CNT_W-1:0]    count;
  logic [NUM_TAPS-1:0] tap_fire;

  rtt_ctrl_regs #(
    .DATA_W   (DATA_W),
    .NUM_TAPS (NUM_TAPS)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .enable      (enable),
    .clear_pulse (clear_pulse),
    .ack_mask    (ack_mask)
  );

  rtt_counter #(
    .CNT_W    (CNT_W),
    .NUM_TAPS (NUM_TAPS)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .enable   (enable),
    .clear    (clear_pulse),
    .count    (count),
    .tap_fire (tap_fire)
  );

  rtt_pending #(
    .NUM_TAPS (NUM_TAPS)
  ) u_pend (
    .clk     (clk),
    .rst     (rst),
    .fire    (tap_fire),
    .ack     (ack_mask),
    .pending (irq_pending)
  );

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_vec
    assign irq_vectors[gi*8 +: 8] = VEC_BASE + 8'(gi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        SEL_CTRL:  rd_data <= DATA_W'(enable);
        SEL_COUNT: rd_data <= DATA_W'(count);
        SEL_PEND:  rd_data <= DATA_W'(irq_pending);
        default:   rd_data <= '0;
      endcase
    end
  end

  // R8: a full wrap raises every rate at once
  a_r8_all_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && enable && !clear_pulse && (&count)) |=> (&irq_pending));

  // R9: a control clear adds no new pending flag
  a_r9_clear_silent: assert property (@(posedge clk) disable iff (rst)
    clear_pulse |=> ((irq_pending & ~$past(irq_pending)) == '0));

  // R1: the clear strobe never shows in the control readback
  a_r1_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == SEL_CTRL) |=> (rd_data[CTRL_CLEAR_BIT] == 1'b0));

  // R12: reset empties count and flags
  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && irq_pending == '0 && !enable));

endmodule

// File: tb/tb_rate_tap_timer.sv
module tb_rate_tap_timer;

  localparam int CNT_W = 8;
  localparam int DW    = 8;
  localparam int NT    = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic [NT-1:0] irq_pending;
  logic [NT*8-1:0] irq_vectors;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rate_tap_timer #(.CNT_W(CNT_W), .DATA_W(DW), .NUM_TAPS(NT)) dut (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .irq_pending (irq_pending),
    .irq_vectors (irq_vectors)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_TK = 2'd1, OP_RD = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_PEND = 2'd2, A_ACK = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] addr;
    logic [8:0] arg;
    logic [7:0] exp;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 34;
  localparam step_t STEPS [NSTEP] = '{
    '{OP_WR, A_CTRL, 9'd1,   8'd0,   4'd1},   // enable
    '{OP_RD, A_CTRL, 9'd0,   8'd1,   4'd1},   // R1 readback
    '{OP_TK, A_CTRL, 9'd7,   8'd0,   4'd3},
    '{OP_RD, A_CNT,  9'd0,   8'd7,   4'd3},   // R3
    '{OP_RD, A_PEND, 9'd0,   8'd0,   4'd5},   // R5 no carry yet
    '{OP_TK, A_CTRL, 9'd1,   8'd0,   4'd5},
    '{OP_RD, A_CNT,  9'd0,   8'd8,   4'd3},
    '{OP_RD, A_PEND, 9'd0,   8'd1,   4'd5},   // R5 carry into bit 3
    '{OP_WR, A_ACK,  9'd0,   8'd0,   4'd6},
    '{OP_RD, A_PEND, 9'd0,   8'd1,   4'd6},   // R6 zero ack ignored
    '{OP_WR, A_ACK,  9'd1,   8'd0,   4'd6},
    '{OP_RD, A_PEND, 9'd0,   8'd0,   4'd6},   // R6 ack clears
    '{OP_TK, A_CTRL, 9'd24,  8'd0,   4'd5},
    '{OP_RD, A_PEND, 9'd0,   8'd3,   4'd5},   // R5 carry into bit 5
    '{OP_WR, A_ACK,  9'd15,  8'd0,   4'd6},
    '{OP_TK, A_CTRL, 9'd96,  8'd0,   4'd5},
    '{OP_RD, A_CNT,  9'd0,   8'd128, 4'd3},
    '{OP_RD, A_PEND, 9'd0,   8'd7,   4'd5},   // R5 carry into bit 7
    '{OP_WR, A_CTRL, 9'd0,   8'd0,   4'd4},
    '{OP_TK, A_CTRL, 9'd5,   8'd0,   4'd4},
    '{OP_RD, A_CNT,  9'd0,   8'd128, 4'd4},   // R4 hold
    '{OP_RD, A_CTRL, 9'd0,   8'd0,   4'd1},
    '{OP_WR, A_ACK,  9'd15,  8'd0,   4'd6},
    '{OP_WR, A_CTRL, 9'd3,   8'd0,   4'd2},
    '{OP_RD, A_CNT,  9'd0,   8'd0,   4'd2},   // R2 clear
    '{OP_RD, A_CTRL, 9'd0,   8'd1,   4'd1},   // R1 clear bit reads 0
    '{OP_RD, A_PEND, 9'd0,   8'd0,   4'd9},   // R9 clear is silent
    '{OP_TK, A_CTRL, 9'd255, 8'd0,   4'd5},
    '{OP_RD, A_PEND, 9'd0,   8'd7,   4'd5},
    '{OP_WR, A_ACK,  9'd15,  8'd0,   4'd6},
    '{OP_TK, A_CTRL, 9'd1,   8'd0,   4'd8},
    '{OP_RD, A_PEND, 9'd0,   8'd15,  4'd8},   // R8 all four on wrap
    '{OP_RD, A_CNT,  9'd0,   8'd0,   4'd3},   // R3 wrap to 0
    '{OP_RD, A_ACK,  9'd0,   8'd0,   4'd10}   // R10 address 3 reads 0
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    do_reset();

    // R12: reset state
    check(12, 32'(irq_pending), 32'd0);
    do_read(A_CNT, rv);  check(12, 32'(rv), 32'd0);
    do_read(A_CTRL, rv); check(12, 32'(rv), 32'd0);
    // R4: ticks while disabled after reset
    do_ticks(3);
    do_read(A_CNT, rv);  check(4, 32'(rv), 32'd0);

    // Table walk
    for (int s = 0; s < NSTEP; s++) begin
      case (STEPS[s].op)
        OP_WR: do_write(STEPS[s].addr, STEPS[s].arg[7:0]);
        OP_TK: do_ticks(int'(STEPS[s].arg));
        default: begin
          do_read(STEPS[s].addr, rv);
          check(int'(STEPS[s].req), 32'(rv), 32'(STEPS[s].exp));
        end
      endcase
    end
    // R5: port matches register view after the wrap
    check(5, 32'(irq_pending), 32'hF);

    // R2: clear and tick in the same cycle
    do_ticks(3);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 8'h03;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    do_read(A_CNT, rv); check(2, 32'(rv), 32'd0);

    // R7: acknowledge and set collide
    do_write(A_ACK, 8'h0F);
    do_ticks(7);
    check(7, 32'(irq_pending), 32'd0);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = A_ACK; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check(7, 32'(irq_pending), 32'd1);
    do_read(A_CNT, rv); check(3, 32'(rv), 32'd8);

    // R11: vector numbers per pending bit
    check(11, irq_vectors, 32'h0E0D0C0B);

    // R12: mid-run reset
    do_ticks(5);
    do_reset();
    check(12, 32'(irq_pending), 32'd0);
    do_read(A_CNT, rv);  check(12, 32'(rv), 32'd0);
    do_read(A_CTRL, rv); check(12, 32'(rv), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule